// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable cell of a logic fabric. It holds two 4-input lookup tables (A and B), a 3-input merge table (M) that combines their results with one extra input, two combinational outputs, two registered outputs and the selection multiplexers between them. Every table entry and every multiplexer choice is a bit in a serial configuration chain. The chain is loaded while the configuration enable is high, and it then stays fixed while the cell computes user logic.

Because the merge table is addressed by the extra input and the two table results, either combinational output can implement any function of up to nine inputs, provided that function splits into the two 4-input tables. Each registered output captures either its combinational output or a separate bypass input. The flip-flops have a synchronous reset whose value comes from the configuration. The last bit of the chain is brought out, so a loaded configuration can be read back. The same pin feeds the next cell when cells are cascaded.

Top module: `lut_logic_cell`

## Requirements
- R1: Table A output equals configuration bit `lut_a_i` (bits 15..0 hold table A, the bit index being the 4-bit input value). Table B output equals bit `16 + lut_b_i` (bits 31..16).
- R2: The merge table output equals configuration bit `32 + {mrg_i, tableA_out, tableB_out}`, so bits 39..32 hold the merge table and `mrg_i` is the address MSB.
- R3: `comb_a_o` shows table A when bit 40 is 0 and the merge table when it is 1. `comb_b_o` shows table B when bit 41 is 0 and the merge table when it is 1.
- R4: On each rising clock edge with `rst` and `cfg_en` low, `reg_a_o` captures the combinational A value when bit 42 is 0, or `byp_a_i` when it is 1. `reg_b_o` does the same with bit 43 and `byp_b_i`.
- R5: When `rst` is high at a rising edge, `reg_a_o` loads bit 44 and `reg_b_o` loads bit 45. Reset takes priority over `cfg_en`.
- R6: While `cfg_en` is high, each rising edge moves every chain bit down one position and writes `cfg_si` into bit 45. Loading therefore sends bit 0 first. While `cfg_en` is low, the chain never changes.
- R7: `cfg_so` always shows chain bit 0, so shifting out reads back the configuration in order from bit 0 to bit 45.
- R8: While `cfg_en` is high, `comb_a_o` and `comb_b_o` are 0 and the flip-flops keep their value unless `rst` is high.
- R9: At power-up the chain holds all zeros, so every table gives 0 for every input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the two flip-flops |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_si | input | 1 | Configuration serial data in |
| cfg_so | output | 1 | Configuration serial data out (chain bit 0) |
| lut_a_i | input | 4 | Table A address |
| lut_b_i | input | 4 | Table B address |
| mrg_i | input | 1 | Extra merge-table address bit (MSB) |
| byp_a_i | input | 1 | Bypass data for flip-flop A |
| byp_b_i | input | 1 | Bypass data for flip-flop B |
| comb_a_o | output | 1 | Combinational output A |
| comb_b_o | output | 1 | Combinational output B |
| reg_a_o | output | 1 | Registered output A |
| reg_b_o | output | 1 | Registered output B |

## Verification
The bench loads random configurations and checks both outputs against a model of the tables and multiplexers. A merge table addressed in the wrong order, or a swapped multiplexer select, shows up as a mismatch on some input pattern. Directed cases cover the following:
- A chain read back bit by bit, which exposes a reversed shift direction or an off-by-one in the load.
- Outputs held at zero during loading, together with the flip-flops freezing, which catches a cell that leaks partial configurations.
- A reset asserted during loading, which must still load the configured values.
- An all-zero power-up, which must give zeros everywhere.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int LUT_IN    = 4;
  localparam int LUT_DEPTH = 1 << LUT_IN;
  localparam int MRG_IN    = 3;
  localparam int MRG_DEPTH = 1 << MRG_IN;

  // Last field sits at bit 0; chain bit index equals packed bit index.
  typedef struct packed {
    logic                 reg_b_init;
    logic                 reg_a_init;
    logic                 reg_b_byp;
    logic                 reg_a_byp;
    logic                 comb_b_mrg;
    logic                 comb_a_mrg;
    logic [MRG_DEPTH-1:0] mrg_tab;
    logic [LUT_DEPTH-1:0] b_tab;
    logic [LUT_DEPTH-1:0] a_tab;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int N_IN = 4
) (
  input  logic [(1<<N_IN)-1:0] tab_i,
  input  logic [N_IN-1:0]      addr_i,
  output logic                 out_o
);
  always_comb out_o = tab_i[addr_i];
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o,
  output logic         dout_o
);
  logic [W-1:0] sh_q = '0;

  always_ff @(posedge clk) begin
    if (en_i) sh_q <= {din_i, sh_q[W-1:1]};
  end

  assign q_o    = sh_q;
  assign dout_o = sh_q[0];

  // R6: chain frozen while not loading
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(sh_q));
endmodule

// File: rtl/cell_ff.sv
module cell_ff (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic init_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)          q_o <= init_i;
    else if (!hold_i) q_o <= d_i;
  end

  // R8: hold while configuring
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(q_o));
  // R5: reset loads configured value
  a_r5_init: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_o == $past(init_i)));
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lut_cell_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_si,
  output logic              cfg_so,
  input  logic [LUT_IN-1:0] lut_a_i,
  input  logic [LUT_IN-1:0] lut_b_i,
  input  logic              mrg_i,
  input  logic              byp_a_i,
  input  logic              byp_b_i,
  output logic              comb_a_o,
  output logic              comb_b_o,
  output logic              reg_a_o,
  output logic              reg_b_o
);
  logic [CFG_W-1:0] chain_q;
  cell_cfg_t        cfg;

  cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst(rst), .en_i(cfg_en), .din_i(cfg_si),
    .q_o(chain_q), .dout_o(cfg_so)
  );
  assign cfg = cell_cfg_t'(chain_q);

  // Two 4-input tables: index 0 = A, 1 = B
  logic [LUT_DEPTH-1:0] tab  [2];
  logic [LUT_IN-1:0]    addr [2];
  logic                 lout [2];
  assign tab[0]  = cfg.a_tab;
  assign tab[1]  = cfg.b_tab;
  assign addr[0] = lut_a_i;
  assign addr[1] = lut_b_i;

  for (genvar i = 0; i < 2; i++) begin : g_lut
    lut_table #(.N_IN(LUT_IN)) u_lut (
      .tab_i(tab[i]), .addr_i(addr[i]), .out_o(lout[i])
    );
  end

  logic mrg_out;
  lut_table #(.N_IN(MRG_IN)) u_mrg (
    .tab_i(cfg.mrg_tab), .addr_i({mrg_i, lout[0], lout[1]}), .out_o(mrg_out)
  );

  logic [1:0] comb_raw, sel_mrg, sel_byp, init_v, byp_v, ff_d, ff_q;
  assign sel_mrg = {cfg.comb_b_mrg, cfg.comb_a_mrg};
  assign sel_byp = {cfg.reg_b_byp, cfg.reg_a_byp};
  assign init_v  = {cfg.reg_b_init, cfg.reg_a_init};
  assign byp_v   = {byp_b_i, byp_a_i};

  for (genvar i = 0; i < 2; i++) begin : g_out
    assign comb_raw[i] = sel_mrg[i] ? mrg_out : lout[i];
    assign ff_d[i]     = sel_byp[i] ? byp_v[i] : comb_raw[i];
    cell_ff u_ff (
      .clk(clk), .rst(rst), .hold_i(cfg_en), .init_i(init_v[i]),
      .d_i(ff_d[i]), .q_o(ff_q[i])
    );
  end

  assign comb_a_o = comb_raw[0] & ~cfg_en;
  assign comb_b_o = comb_raw[1] & ~cfg_en;
  assign reg_a_o  = ff_q[0];
  assign reg_b_o  = ff_q[1];

  // R8: combinational outputs quiet during load
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (!comb_a_o && !comb_b_o));
  // R3: A output follows table A when merge not selected
  a_r3_route_a: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !cfg.comb_a_mrg) |-> (comb_a_o == lout[0]));
  // R3: B output follows merge table when selected
  a_r3_route_b: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && cfg.comb_b_mrg) |-> (comb_b_o == mrg_out));
endmodule

// File: tb/lut_logic_cell_tb.sv
`timescale 1ns/1ps
module lut_logic_cell_tb;
  logic clk = 0, rst = 1, cfg_en = 0, cfg_si = 0;
  logic [3:0] lut_a_i = 0, lut_b_i = 0;
  logic mrg_i = 0, byp_a_i = 0, byp_b_i = 0;
  logic cfg_so, comb_a_o, comb_b_o, reg_a_o, reg_b_o;
  int n_chk = 0, n_fail = 0;
  logic done = 0;
  logic [45:0] cur;

  always #2 clk = ~clk;

  lut_logic_cell u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [45:0] c, input logic [3:0] a,
                                       input logic [3:0] b, input logic m);
    logic fa, fb, fm;
    fa = c[a];
    fb = c[16 + b];
    fm = c[32 + {m, fa, fb}];
    return {c[41] ? fm : fb, c[40] ? fm : fa};
  endfunction

  task automatic load(input logic [45:0] c);
    for (int i = 0; i < 46; i++) begin
      @(negedge clk); cfg_en = 1; cfg_si = c[i];
    end
    @(negedge clk); cfg_en = 0; cfg_si = 0;
    cur = c;
  endtask

  task automatic apply_and_check(input logic [3:0] a, input logic [3:0] b,
                                 input logic m, input logic ba, input logic bb);
    logic [1:0] e;
    @(negedge clk);
    lut_a_i = a; lut_b_i = b; mrg_i = m; byp_a_i = ba; byp_b_i = bb;
    #0.5;
    e = model(cur, a, b, m);
    chk("R1/R2/R3 comb_a", comb_a_o, e[0]);
    chk("R1/R2/R3 comb_b", comb_b_o, e[1]);
    @(negedge clk);
    chk("R4 reg_a", reg_a_o, cur[42] ? ba : e[0]);
    chk("R4 reg_b", reg_b_o, cur[43] ? bb : e[1]);
  endtask

  initial begin
    logic [45:0] c;
    logic ha, hb;
    int seed;
    seed = $urandom(32'h5EED1);
    // R9: power-up zeros
    lut_a_i = 4'hF; lut_b_i = 4'h9; mrg_i = 1;
    #1;
    chk("R9 comb_a zero", comb_a_o, 1'b0);
    chk("R9 comb_b zero", comb_b_o, 1'b0);
    @(negedge clk); @(negedge clk); rst = 0;
    chk("R5 reg_a reset zero", reg_a_o, 1'b0);
    chk("R5 reg_b reset zero", reg_b_o, 1'b0);
    cur = '0;
    apply_and_check(4'h3, 4'hC, 1'b1, 1'b0, 1'b0);

    // R5: configured reset values
    c = '0; c[44] = 1; c[45] = 1;
    load(c);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R5 reg_a init one", reg_a_o, 1'b1);
    chk("R5 reg_b init one", reg_b_o, 1'b1);

    // R1/R2/R3/R4: random configurations and inputs
    for (int k = 0; k < 14; k++) begin
      c = {$urandom, $urandom};
      if (k == 0) c[43:40] = 4'b0000;
      if (k == 1) c[43:40] = 4'b1111;
      load(c);
      for (int v = 0; v < 16; v++)
        apply_and_check(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R2: nine-input AND through merge table (merge = bit 7 only)
    c = '0; c[15] = 1; c[31] = 1; c[39] = 1; c[41:40] = 2'b11;
    load(c);
    apply_and_check(4'hF, 4'hF, 1'b1, 1'b0, 1'b0);
    apply_and_check(4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
    apply_and_check(4'hE, 4'hF, 1'b1, 1'b0, 1'b0);

    // R8: hold during load
    c = {$urandom, $urandom}; c[41:40] = 2'b00; c[15:0] = 16'hFFFF; c[31:16] = 16'hFFFF;
    load(c);
    apply_and_check(4'h1, 4'h2, 1'b0, 1'b1, 1'b0);
    ha = reg_a_o; hb = reg_b_o;
    @(negedge clk); cfg_en = 1; cfg_si = 0; byp_a_i = ~byp_a_i; byp_b_i = ~byp_b_i;
    #0.5;
    chk("R8 comb_a zero in load", comb_a_o, 1'b0);
    chk("R8 comb_b zero in load", comb_b_o, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R8 reg_a held", reg_a_o, ha);
    chk("R8 reg_b held", reg_b_o, hb);
    cfg_en = 0;

    // R5: reset wins over cfg_en
    c = '0; c[44] = 1; c[45] = 0;
    load(c);
    @(negedge clk); rst = 1; cfg_en = 1; cfg_si = 0;
    @(negedge clk); rst = 0; cfg_en = 0;
    chk("R5 reset during load a", reg_a_o, 1'b1);
    chk("R5 reset during load b", reg_b_o, 1'b0);

    // R6/R7: readback after idle cycles
    c = {$urandom, $urandom};
    load(c);
    repeat (5) apply_and_check(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < 46; i++) begin
      @(negedge clk);
      chk($sformatf("R6/R7 readback bit %0d", i), cfg_so, c[i]);
      cfg_en = 1; cfg_si = 0;
    end
    @(negedge clk); cfg_en = 0;
    cur = '0;
    apply_and_check(4'h7, 4'hB, 1'b1, 1'b0, 1'b0);
    chk("R7 cfg_so after flush", cfg_so, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule